// File: doc/BRIEF.md
# Track-Crossing Counter and Brake-Interval Status Line

This block produces one status line for a host controller in an optical-disc servo path. The line serves two functions, and a mode field picks which one drives it. In track mode, the block counts rising edges of an asynchronous track-crossing pulse input. It compares the running count with a target written by the host. When the count reaches that target, the line either falls low and stays low, or inverts and lets counting start again. A second mode field chooses between these two behaviours.

In brake mode, the block measures the gap between successive run-length edges. The unit of measure is a channel bit period T, set as a fixed number of system clocks. When a gap reaches 32 T, the line is pulled low. A gap that long means braking has brought the disc speed down to about a third of nominal. The next edge releases the line.

The host loads all three settings (target, toggle enable, brake select) together with one write strobe. Every write restarts both the counter and the interval timer. This is also how the host re-arms the line after a match in the go-low behaviour.

Top module: `trk_brake_status`

## Requirements
- R1: During and after a synchronous active-low reset, `status_o` is 1. After reset, target is 0, toggle is off and track mode is selected.
- R2: Only rising edges of `trk_pulse_i` are counted, after a two-stage synchroniser. An input held high counts once. A rising edge present before clock edge n changes `status_o` after clock edge n+2.
- R3: With toggle off and track mode selected, `status_o` drops to 0 when the count equals the non-zero target. It remains 0 under any further pulses until the next write.
- R4: A write with `cfg_we`=1 clears the count, the toggle level and the match latch. In track mode `status_o` is then 1.
- R5: With toggle on, every time the count reaches the target, `status_o` inverts and the count restarts from zero.
- R6: A target of 0 never matches, and `status_o` stays 1 in track mode.
- R7: With brake selected, `status_o` becomes 0 once RUN_T*T_CLKS clocks (32 T by default) have passed since the last run-length edge or the last write, with no new edge arriving.
- R8: In brake mode, a run-length edge (`rl_edge_i`=1) restarts the interval timer, and `status_o` is 1 after that clock edge.
- R9: While brake mode is selected, track pulses have no effect on `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for the three settings below |
| cfg_target | input | CNT_W | Count target; 0 disables matching |
| cfg_toggle | input | 1 | 1: invert on each match; 0: go low and hold |
| cfg_brake | input | 1 | 1: brake-interval function drives the line; 0: track counter drives it |
| trk_pulse_i | input | 1 | Asynchronous track-crossing pulses |
| rl_edge_i | input | 1 | One-clock pulse per detected run-length edge, synchronous |
| status_o | output | 1 | Status line to host |

## Verification
The bench checks the exact cycle of each match, allowing for the synchroniser delay. A count that is off by one, or an edge detector that counts levels rather than edges, shows up as a mismatch on that cycle. A long high input and pulses arriving after a go-low match are applied to expose a missing match latch. Toggle mode is run across several match periods, so a counter that is not cleared on a match inverts the line at the wrong times. Brake gaps just below and above 32 T, edges that release the flag, and track pulses applied during brake mode check the timer bound and the selection between the two functions.

// File: rtl/tbs_pkg.sv
// Shared types for the track/brake status block.
package tbs_pkg;
    // Source selector for the status line.
    typedef enum logic {
        SEL_TRACK = 1'b0,
        SEL_BRAKE = 1'b1
    } sel_e;
endpackage

// File: rtl/tbs_edge_sync.sv
// Synchronises an asynchronous input through SYNC_STAGES flops and emits
// a one-clock pulse per rising edge. Assumes input pulses stay at each
// level for at least one clock.
module tbs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] sh;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], async_i};
    end

    assign rise_o = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tbs_track_counter.sv
// Counts synchronised rising edges and compares the count with a target.
// Go-low behaviour latches a match until the next write. Toggle behaviour
// inverts a level on each match and restarts the count. Target 0 never
// matches. A write clears all state.
module tbs_track_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             toggle_i,
    input  logic             rise_i,
    output logic             level_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;
    logic             tog_lvl;
    logic             armed;

    assign cnt_nxt = cnt + 1'b1;
    assign armed   = (target_i != '0) && !hit;

    // Counter, match latch and toggle level update.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_i) begin
            cnt     <= '0;
            hit     <= 1'b0;
            tog_lvl <= 1'b1;
        end else if (rise_i && armed) begin
            if (cnt_nxt == target_i) begin
                if (toggle_i) begin
                    cnt     <= '0;
                    tog_lvl <= ~tog_lvl;
                end else begin
                    cnt <= cnt_nxt;
                    hit <= 1'b1;
                end
            end else begin
                cnt <= cnt_nxt;
            end
        end
    end

    assign level_o = toggle_i ? tog_lvl : ~hit;

    // R3
    hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !wr_i |=> hit);
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_i != '0) |-> (cnt <= target_i));
endmodule

// File: rtl/tbs_run_timer.sv
// Measures clocks since the last run-length edge while enabled and flags
// a gap of LIMIT clocks or more. Saturates at LIMIT. Assumes the edge
// input is already synchronous.
module tbs_run_timer #(
    parameter int LIMIT = 128,
    localparam int TMR_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic edge_i,
    output logic long_o
);
    logic [TMR_W-1:0] tmr;

    // Interval counter: restarts on clear, disable or edge; saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !en_i || edge_i) tmr <= '0;
        else if (tmr != TMR_W'(LIMIT))          tmr <= tmr + 1'b1;
    end

    assign long_o = (tmr == TMR_W'(LIMIT));

    // R7
    tmr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= TMR_W'(LIMIT));
endmodule

// File: rtl/trk_brake_status.sv
// Status line shared by a track-crossing counter and a brake-interval
// detector. Settings are loaded by one host write strobe. The line is high
// from reset. T_CLKS system clocks make one channel bit period.
module trk_brake_status #(
    parameter int CNT_W       = 8,
    parameter int T_CLKS      = 4,
    parameter int RUN_T       = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LIMIT      = RUN_T * T_CLKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic             cfg_toggle,
    input  logic             cfg_brake,
    input  logic             trk_pulse_i,
    input  logic             rl_edge_i,
    output logic             status_o
);
    import tbs_pkg::*;

    logic [CNT_W-1:0] target_q;
    logic             toggle_q;
    sel_e             sel_q;
    logic             rise;
    logic             trk_level;
    logic             long_gap;

    // Host settings register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            toggle_q <= 1'b0;
            sel_q    <= SEL_TRACK;
        end else if (cfg_we) begin
            target_q <= cfg_target;
            toggle_q <= cfg_toggle;
            sel_q    <= cfg_brake ? SEL_BRAKE : SEL_TRACK;
        end
    end

    tbs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trk_pulse_i),
        .rise_o  (rise)
    );

    tbs_track_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_we),
        .target_i (target_q),
        .toggle_i (toggle_q),
        .rise_i   (rise),
        .level_o  (trk_level)
    );

    tbs_run_timer #(.LIMIT(LIMIT)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_we),
        .en_i   (sel_q == SEL_BRAKE),
        .edge_i (rl_edge_i),
        .long_o (long_gap)
    );

    assign status_o = (sel_q == SEL_BRAKE) ? ~long_gap : trk_level;

    // R1
    reset_high_chk: assert property (@(posedge clk)
        !rst_n |=> status_o);
    // R8
    edge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_BRAKE) && rl_edge_i && !cfg_we |=> status_o);
endmodule

// File: tb/tb_trk_brake_status.sv
module tb_trk_brake_status;
    localparam int CNT_W = 8;
    localparam int T_CLKS = 4;
    localparam int LIMIT = 32 * T_CLKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CNT_W-1:0] cfg_target = '0;
    logic cfg_toggle = 1'b0;
    logic cfg_brake = 1'b0;
    logic trk_pulse_i = 1'b0;
    logic rl_edge_i = 1'b0;
    logic status_o;

    always #10 clk = ~clk;

    trk_brake_status #(.CNT_W(CNT_W), .T_CLKS(T_CLKS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
        .cfg_toggle(cfg_toggle), .cfg_brake(cfg_brake),
        .trk_pulse_i(trk_pulse_i), .rl_edge_i(rl_edge_i), .status_o(status_o)
    );

    int vectors = 0;
    int fails = 0;
    string req = "R1";

    // reference model state
    int m_tgt = 0, m_cnt = 0, m_tmr = 0;
    bit m_tog = 0, m_brk = 0, m_hit = 0, m_lvl = 1;
    bit d1 = 0, d2 = 0, d3 = 0;

    function automatic bit exp_status();
        if (m_brk) return !(m_tmr >= LIMIT);
        return m_tog ? m_lvl : !m_hit;
    endfunction

    task automatic cyc(input bit rs, input bit wr, input int tgt, input bit tg,
                       input bit bk, input bit p, input bit e);
        bit rise;
        @(negedge clk);
        vectors++;
        if (status_o !== exp_status()) begin
            fails++;
            $display("FAIL %s: status_o=%b expected %b at vector %0d",
                     req, status_o, exp_status(), vectors);
        end
        rst_n = rs; cfg_we = wr; cfg_target = CNT_W'(tgt);
        cfg_toggle = tg; cfg_brake = bk; trk_pulse_i = p; rl_edge_i = e;
        rise = d2 && !d3;
        if (!rs) begin
            m_tgt = 0; m_tog = 0; m_brk = 0; m_cnt = 0; m_hit = 0; m_lvl = 1;
            m_tmr = 0; d1 = 0; d2 = 0; d3 = 0;
        end else begin
            if (wr) begin
                m_cnt = 0; m_hit = 0; m_lvl = 1; m_tmr = 0;
            end else begin
                if (rise && m_tgt != 0 && !m_hit) begin
                    if (m_cnt + 1 == m_tgt) begin
                        if (m_tog) begin m_cnt = 0; m_lvl = !m_lvl; end
                        else begin m_cnt = m_cnt + 1; m_hit = 1; end
                    end else m_cnt = m_cnt + 1;
                end
                if (!m_brk || e) m_tmr = 0;
                else if (m_tmr < LIMIT) m_tmr = m_tmr + 1;
            end
            if (wr) begin m_tgt = tgt; m_tog = tg; m_brk = bk; end
            d3 = d2; d2 = d1; d1 = p;
        end
    endtask

    task automatic idle(input int n, input bit p = 0);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, p, 0);
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            cyc(1, 0, 0, 0, 0, 1, 0); cyc(1, 0, 0, 0, 0, 1, 0);
            cyc(1, 0, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic wr(input int tgt, input bit tg, input bit bk);
        cyc(1, 1, tgt, tg, bk, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        req = "R1";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0);
        idle(6);
        req = "R6";   // reset target 0: pulses never match
        pulses(3); idle(4);

        req = "R2"; wr(5, 0, 0); pulses(4); idle(4);
        req = "R3"; pulses(1); idle(4); pulses(3); idle(4);

        req = "R4"; wr(3, 0, 0); idle(3); pulses(3); idle(4);

        req = "R2"; wr(2, 0, 0); idle(20, 1); idle(5); pulses(1); idle(4);

        req = "R5"; wr(2, 1, 0); pulses(7); idle(4); wr(3, 1, 0); pulses(10); idle(4);

        req = "R6"; wr(0, 1, 0); pulses(6); wr(0, 0, 0); pulses(6); idle(3);

        req = "R7"; wr(4, 0, 1); idle(LIMIT - 2); idle(10);
        req = "R8"; cyc(1, 0, 0, 0, 0, 0, 1); idle(3);
        for (int k = 0; k < 5; k++) begin idle(LIMIT - 1); cyc(1, 0, 0, 0, 0, 0, 1); end
        req = "R7"; idle(LIMIT + 5);
        req = "R8"; cyc(1, 0, 0, 0, 0, 0, 1); idle(2);

        req = "R9"; wr(3, 0, 1);
        for (int i = 0; i < 64; i++) cyc(1, 0, 0, 0, 0, (i % 4) < 2, (i % 8) == 0);
        req = "R4"; wr(3, 0, 0); idle(4); pulses(3); idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule